// File: doc/BRIEF.md
# Register-Indirect Jump Resolver with Fetch-Alignment Trap

This execute-stage unit resolves a register-indirect jump-and-link on a 64-bit core. It adds a source register to a sign-extended 12-bit offset, clears bit 0 of the result, and then decides whether the destination is a legal fetch address. Whether an address is legal depends on whether 16-bit compressed instructions are enabled.

A legal jump produces a one-cycle redirect pulse that carries the target. It also writes the return address to the destination register, unless that register is x0. An illegal jump raises a trap instead. The trap carries the misaligned-instruction-fetch cause and the address of the jump itself, and the register write is suppressed. Results are registered, so they appear one clock after the valid strobe.

The parameter `HAS_COMPRESSED` selects the build. When it is 1, the runtime compressed-enable flag sets the alignment granule. When it is 0, the flag is ignored and every target must be 4-byte aligned.

Top module: `ijmp_unit`

## Requirements
- R1: The target is rs1 plus the sign-extended offset with bit 0 forced to zero, and a redirect presents exactly that value on `redir_pc_o`.
- R2: A sum whose bit 0 is set but whose bit 1 is clear (for example base+1 on a 4-byte-aligned base) never traps and redirects to the aligned address.
- R3: With compressed instructions disabled, a target whose bit 1 is set (base+2, base+3) raises `trap_o` and no redirect.
- R4: With compressed instructions enabled and `HAS_COMPRESSED`=1, a target with bit 1 set redirects without a trap. With `HAS_COMPRESSED`=0 the flag has no effect and such a target traps.
- R5: A trapping jump never asserts `rf_we_o`.
- R6: `trap_epc_o` equals the PC of the jump, not its target.
- R7: `trap_cause_o` is 0 (exception code 0, interrupt bit 63 clear) during a trap. Cause and EPC read 0 when no trap is signalled.
- R8: A legal jump writes PC+4 to `rf_waddr_o`=rd. When rd is 0 no write occurs, and write address and data read 0 whenever `rf_we_o` is low.
- R9: Outputs respond in the cycle after a valid strobe as single-cycle pulses. Without valid, trap, redirect and write all stay low. Trap and redirect are never high together.
- R10: While reset is asserted every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid_i | input | 1 | Jump instruction valid this cycle |
| rs1_val_i | input | 64 | Base register value |
| imm_i | input | 12 | Signed offset field |
| pc_i | input | 64 | Address of the jump instruction |
| rd_idx_i | input | 5 | Destination register index |
| cmp_en_i | input | 1 | Compressed instructions enabled |
| trap_o | output | 1 | Misaligned-fetch trap request |
| trap_cause_o | output | 64 | Trap cause value |
| trap_epc_o | output | 64 | Exception PC |
| redir_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | 64 | Redirect target |
| rf_we_o | output | 1 | Link register write enable |
| rf_waddr_o | output | 5 | Link register index |
| rf_wdata_o | output | 64 | Link value |

## Verification
The bench instantiates the unit twice on shared stimulus. `dut` uses `HAS_COMPRESSED`=1 and `dut_rvi` uses `HAS_COMPRESSED`=0. With this pairing, a single sweep of the target's low two bits, with the runtime flag both on and off, covers the 2-byte and 4-byte alignment rules. It also shows that the 4-byte-only build ignores the flag. Negative offsets, odd base values, rd=0 and gaps in the valid strobe exercise the carry into bit 1, the write suppression and the pulse behaviour.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;

    // Exception code for an instruction fetch from a misaligned address.
    localparam int unsigned EXC_FETCH_MISALIGNED = 0;

    // Alignment granule required for a fetch target.
    typedef enum logic {
        GRAN_HALF = 1'b0,
        GRAN_WORD = 1'b1
    } fetch_gran_e;

endpackage

// File: rtl/ijmp_target_calc.sv
module ijmp_target_calc #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 12
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  target_o
);
    localparam int unsigned EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] sum;

    always_comb begin
        imm_sx   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        sum      = base_i + imm_sx;
        target_o = sum & ~XLEN'(1);
    end
endmodule

// File: rtl/ijmp_align_chk.sv
module ijmp_align_chk
    import ijmp_pkg::*;
#(
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic        tgt_bit1_i,
    input  logic        cmp_en_i,
    output fetch_gran_e gran_o,
    output logic        misaligned_o
);
    generate
        if (HAS_COMPRESSED) begin : g_dyn
            always_comb gran_o = cmp_en_i ? GRAN_HALF : GRAN_WORD;
        end else begin : g_word
            logic unused_cmp;
            assign unused_cmp = cmp_en_i;
            always_comb gran_o = GRAN_WORD;
        end
    endgenerate

    // Bit 0 is already clear; only bit 1 can break word alignment.
    always_comb misaligned_o = (gran_o == GRAN_WORD) && tgt_bit1_i;
endmodule

// File: rtl/ijmp_link_gen.sv
module ijmp_link_gen #(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned RIDX_W     = 5,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic              legal_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [RIDX_W-1:0] rd_i,
    output logic              we_o,
    output logic [XLEN-1:0]   link_o
);
    always_comb begin
        we_o   = legal_i && (rd_i != '0);
        link_o = pc_i + XLEN'(INSN_BYTES);
    end
endmodule

// File: rtl/ijmp_unit.sv
module ijmp_unit
    import ijmp_pkg::*;
#(
    parameter int unsigned XLEN           = 64,
    parameter int unsigned IMM_W          = 12,
    parameter int unsigned RIDX_W         = 5,
    parameter int unsigned INSN_BYTES     = 4,
    parameter bit          HAS_COMPRESSED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid_i,
    input  logic [XLEN-1:0]   rs1_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic              cmp_en_i,
    output logic              trap_o,
    output logic [XLEN-1:0]   trap_cause_o,
    output logic [XLEN-1:0]   trap_epc_o,
    output logic              redir_o,
    output logic [XLEN-1:0]   redir_pc_o,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o
);
    localparam logic [XLEN-1:0] CAUSE_VAL = XLEN'(EXC_FETCH_MISALIGNED);

    typedef struct packed {
        logic              trap;
        logic [XLEN-1:0]   cause;
        logic [XLEN-1:0]   epc;
        logic              redir;
        logic [XLEN-1:0]   tgt;
        logic              we;
        logic [RIDX_W-1:0] waddr;
        logic [XLEN-1:0]   wdata;
    } ex_out_t;

    ex_out_t         st_d, st_q;
    logic [XLEN-1:0] target;
    fetch_gran_e     gran;
    logic            misaligned;
    logic            legal;
    logic            link_we;
    logic [XLEN-1:0] link_val;

    ijmp_target_calc #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .base_i   (rs1_val_i),
        .imm_i    (imm_i),
        .target_o (target)
    );

    ijmp_align_chk #(.HAS_COMPRESSED(HAS_COMPRESSED)) u_align (
        .tgt_bit1_i   (target[1]),
        .cmp_en_i     (cmp_en_i),
        .gran_o       (gran),
        .misaligned_o (misaligned)
    );

    always_comb legal = ex_valid_i && !misaligned;

    ijmp_link_gen #(.XLEN(XLEN), .RIDX_W(RIDX_W), .INSN_BYTES(INSN_BYTES)) u_link (
        .legal_i (legal),
        .pc_i    (pc_i),
        .rd_i    (rd_idx_i),
        .we_o    (link_we),
        .link_o  (link_val)
    );

    always_comb begin
        st_d       = '0;
        st_d.trap  = ex_valid_i && misaligned;
        st_d.redir = legal;
        st_d.we    = link_we;
        if (st_d.trap) begin
            st_d.cause = CAUSE_VAL;
            st_d.epc   = pc_i;
        end
        if (st_d.redir) begin
            st_d.tgt = target;
        end
        if (st_d.we) begin
            st_d.waddr = rd_idx_i;
            st_d.wdata = link_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_o       = st_q.trap;
    assign trap_cause_o = st_q.cause;
    assign trap_epc_o   = st_q.epc;
    assign redir_o      = st_q.redir;
    assign redir_pc_o   = st_q.tgt;
    assign rf_we_o      = st_q.we;
    assign rf_waddr_o   = st_q.waddr;
    assign rf_wdata_o   = st_q.wdata;

    // Word granule with bit 1 set must never reach the redirect path.
    AST_WORD_GRAN_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && gran == GRAN_WORD && target[1]) |=> (trap_o && !redir_o)); // R3
    AST_HALF_GRAN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && gran == GRAN_HALF) |=> (redir_o && !trap_o)); // R4
    AST_REDIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> !redir_pc_o[0]); // R1
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !rf_we_o); // R5
    AST_EPC_IS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && misaligned) |=> (trap_epc_o == $past(pc_i))); // R6
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_cause_o == '0)); // R7
    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_waddr_o != '0)); // R8
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_o && redir_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid_i |=> !(trap_o || redir_o || rf_we_o)); // R9
endmodule

// File: tb/tb_ijmp_unit.sv
`timescale 1ns/1ps
module tb_ijmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0;
    logic [63:0] rs1 = '0;
    logic [11:0] imm = '0;
    logic [63:0] pc = '0;
    logic [4:0]  rd = '0;
    logic        cmp = 1'b0;

    logic        a_trap, a_redir, a_we, b_trap, b_redir, b_we;
    logic [63:0] a_cause, a_epc, a_tgt, a_wd, b_cause, b_epc, b_tgt, b_wd;
    logic [4:0]  a_wa, b_wa;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit trap; logic [63:0] cause; logic [63:0] epc;
        bit redir; logic [63:0] tgt;
        bit we; logic [4:0] wa; logic [63:0] wd;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];

    always #2.5 clk = ~clk;

    ijmp_unit #(.HAS_COMPRESSED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ex_valid_i(v), .rs1_val_i(rs1), .imm_i(imm),
        .pc_i(pc), .rd_idx_i(rd), .cmp_en_i(cmp),
        .trap_o(a_trap), .trap_cause_o(a_cause), .trap_epc_o(a_epc),
        .redir_o(a_redir), .redir_pc_o(a_tgt),
        .rf_we_o(a_we), .rf_waddr_o(a_wa), .rf_wdata_o(a_wd));

    ijmp_unit #(.HAS_COMPRESSED(1'b0)) dut_rvi (
        .clk(clk), .rst_n(rst_n), .ex_valid_i(v), .rs1_val_i(rs1), .imm_i(imm),
        .pc_i(pc), .rd_idx_i(rd), .cmp_en_i(cmp),
        .trap_o(b_trap), .trap_cause_o(b_cause), .trap_epc_o(b_epc),
        .redir_o(b_redir), .redir_pc_o(b_tgt),
        .rf_we_o(b_we), .rf_waddr_o(b_wa), .rf_wdata_o(b_wd));

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(bit hc);
        exp_t e;
        logic [63:0] t;
        bit mis;
        e = '{default: '0};
        t = (rs1 + {{52{imm[11]}}, imm}) & ~64'd1;
        mis = t[1] && !(hc && cmp);
        e.trap  = v && mis;
        e.redir = v && !mis;
        e.we    = e.redir && (rd != 5'd0);
        if (e.trap) begin e.cause = 64'd0; e.epc = pc; end
        if (e.redir) e.tgt = t;
        if (e.we) begin e.wa = rd; e.wd = pc + 64'd4; end
        return e;
    endfunction

    task automatic compare(string tag, exp_t e, bit trap, logic [63:0] cause,
                           logic [63:0] epc, bit redir, logic [63:0] tgt,
                           bit we, logic [4:0] wa, logic [63:0] wd);
        chk({"R3/R4 ", tag}, "trap", 64'(trap), 64'(e.trap));
        chk({"R9 ", tag}, "redir", 64'(redir), 64'(e.redir));
        chk({"R1 ", tag}, "target", tgt, e.tgt);
        chk({"R7 ", tag}, "cause", cause, e.cause);
        chk({"R6 ", tag}, "epc", epc, e.epc);
        chk({"R5/R8 ", tag}, "we", 64'(we), 64'(e.we));
        chk({"R8 ", tag}, "waddr", 64'(wa), 64'(e.wa));
        chk({"R8 ", tag}, "wdata", wd, e.wd);
    endtask

    // One instruction slot: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(bit vv, logic [63:0] b, logic [11:0] im,
                        logic [63:0] p, logic [4:0] r, bit c);
        v = vv; rs1 = b; imm = im; pc = p; rd = r; cmp = c;
        @(posedge clk);
        qa.push_back(model(1'b1));
        qb.push_back(model(1'b0));
        @(negedge clk);
        compare("dut", qa.pop_front(), a_trap, a_cause, a_epc, a_redir, a_tgt, a_we, a_wa, a_wd);
        compare("dut_rvi", qb.pop_front(), b_trap, b_cause, b_epc, b_redir, b_tgt, b_we, b_wa, b_wd);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: outputs cleared during reset
        repeat (3) @(negedge clk);
        chk("R10", "trap", 64'(a_trap), 0);
        chk("R10", "redir", 64'(a_redir), 0);
        chk("R10", "we", 64'(a_we), 0);
        chk("R10", "wdata", a_wd | a_tgt | a_epc | a_cause, 0);
        rst_n = 1'b1;

        // R2 R3 R4: sweep low two target bits with the flag off and on
        for (int c = 0; c < 2; c++) begin
            for (int lo = 0; lo < 4; lo++) begin
                step(1'b1, 64'h0000_0000_8000_1000, 12'(lo),
                     64'h0000_0000_8000_0200 + 64'(lo * 16), 5'd1, c[0]);
            end
        end
        // R1: negative offset, odd base carrying into bit 1
        step(1'b1, 64'h0000_0000_0000_2003, 12'hFFF, 64'h40, 5'd5, 1'b0);
        step(1'b1, 64'h0000_0000_0000_2001, 12'h001, 64'h44, 5'd5, 1'b0);
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 12'h805, 64'h48, 5'd31, 1'b1);
        // R8: rd = 0 never written, legal and trapping
        step(1'b1, 64'h1000, 12'h004, 64'h100, 5'd0, 1'b0);
        step(1'b1, 64'h1000, 12'h002, 64'h104, 5'd0, 1'b0);
        // R9: idle cycles and back-to-back jumps
        step(1'b0, 64'h1000, 12'h002, 64'h108, 5'd3, 1'b0);
        step(1'b1, 64'h1000, 12'h002, 64'h10C, 5'd3, 1'b0);
        step(1'b1, 64'h1000, 12'h000, 64'h110, 5'd3, 1'b0);
        step(1'b0, 64'h1000, 12'h000, 64'h114, 5'd3, 1'b1);
        // R6: EPC differs from target on large PC
        step(1'b1, 64'h0000_7FFF_0000_0006, 12'h7FC, 64'hFFFF_FFFF_FFFF_FFF8, 5'd9, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule